// File: doc/BRIEF.md
# Trace ring capture buffer

The block records a stream of 32-bit trace words into an internal circular RAM. A one-word input stage registers each accepted word, and the next cycle writes it at the write pointer. The pointer then steps one word and wraps at the buffer depth. Software controls and inspects the block through a small register port made of a word address, a write strobe, a read strobe, write data and combinational read data. Through this port software starts and stops capture, requests a manual flush that can end capture, arms a trigger counter, moves the pointers and drains the stored words.

Capture can end in three ways: a write to the control register, a completed flush with the stop option set, or the expiry of the post-trigger word count. Once capture is off and the input stage is empty, the block reports ready. Software may then set the read pointer and read the buffer back one word per read strobe. A read-only identification register reports the memory bus width and the configuration. A depth register reports the buffer size in words.

Top module: `trace_ring_capture`

## Requirements
- R1: Register 0 (control) bit 0 holds the capture enable. Writing 1 starts capture and writing 0 stops it. A trace word is accepted only in a cycle with capture enabled and `trace_valid` high. Reads return the enable in bit 0.
- R2: Each accepted word is written to the RAM one cycle later, at the byte write pointer (register 4). The pointer then advances by 4 and wraps to 0 at 4*DEPTH. Status bit 1 (full) sets when the pointer wraps and stays set until register 4 is written.
- R3: Status register 1 bit 0 (ready) is 1 exactly when capture is disabled and the input stage holds no word.
- R4: Register 6 (flush control) has bit 0 as the flush request and bit 1 as stop-on-flush. Writing bit 0 as 1 sets the request, and the block clears it one cycle later. If stop-on-flush is set when the request clears, capture is disabled in that same edge.
- R5: Register 7 holds the trigger count N. The first cycle with `trace_trig` high while capture is enabled arms the trigger and sets status bit 2. Capture stops at the edge that accepts the N-th later word, or at the trigger edge when N is 0. Enabling capture from the disabled state clears status bit 2.
- R6: A read strobe on register 5 while capture is disabled returns the RAM word at the read pointer and advances the read pointer by 4, with wrap. While capture is enabled, register 5 reads all ones and the pointer does not move.
- R7: A write to the read pointer (register 3) forces its low 4 bits to zero when BUS_BITS is 128 or less, and its low 5 bits when BUS_BITS is 256.
- R8: Writes to registers 3 and 4 are ignored unless the block is ready.
- R9: Register 2 reads the buffer depth in 32-bit words.
- R10: Register 8 reads the bus width code in bits [10:8] (2, 3, 4 or 5 for a 32, 64, 128 or 256-bit bus) and the configuration type 0 in bits [7:6]. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_valid | input | 1 | Trace word present |
| trace_data | input | 32 | Trace word |
| trace_trig | input | 1 | Trigger event |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the read pointer on register 5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The bench builds the block with a depth of 16 words, a 128-bit bus width and an 8-bit trigger count. Twenty words then wrap the buffer and set the full flag. Read-pointer writes show the 4-bit alignment mask, and the identification register shows width code 4. A behavioural model follows every cycle of register and trace activity, including flushes with and without stop, trigger counts of zero and non-zero, and pointer writes attempted during capture.

// File: rtl/trace_ring_capture.sv
module trace_ring_capture #(
  parameter int DEPTH    = 64,
  parameter int BUS_BITS = 32,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_valid,
  input  logic [31:0] trace_data,
  input  logic        trace_trig,
  input  logic [3:0]  reg_addr,
  input  logic        reg_we,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;
  localparam int AL = (BUS_BITS == 256) ? 5 : 4;
  localparam logic [2:0] WCODE = (BUS_BITS == 32) ? 3'd2 : (BUS_BITS == 64) ? 3'd3 :
                                 (BUS_BITS == 128) ? 3'd4 : 3'd5;
  localparam logic [1:0] CFG_TYPE = 2'd0;
  localparam logic [PW-1:0] RP_MASK = {{(PW-AL){1'b1}}, {AL{1'b0}}};
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_SIZE = 4'd2, A_RP = 4'd3,
                         A_WP = 4'd4, A_DATA = 4'd5, A_FLUSH = 4'd6, A_TRIG = 4'd7,
                         A_IDENT = 4'd8;

  logic [31:0]      mem [DEPTH];
  logic             cap_en, st_v, full, flush_pend, stop_flush, trig_seen;
  logic [31:0]      st_d;
  logic [PW-1:0]    wp, rp;
  logic [CNT_W-1:0] trig_cnt, remain;

  wire accept    = cap_en && trace_valid;
  wire ready     = !cap_en && !st_v;
  wire rd_adv    = reg_rd && reg_addr == A_DATA && !cap_en;
  wire trig_fire = cap_en && trace_trig && !trig_seen;
  wire trig_stop = trig_fire ? (trig_cnt == '0)
                             : (cap_en && trig_seen && accept && remain == CNT_W'(1));
  wire ctrl_wr   = reg_we && reg_addr == A_CTRL;

  always_ff @(posedge clk)
    if (st_v) mem[wp[PW-1:2]] <= st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en <= 1'b0; st_v <= 1'b0; st_d <= '0; full <= 1'b0;
      flush_pend <= 1'b0; stop_flush <= 1'b0; trig_seen <= 1'b0;
      wp <= '0; rp <= '0; trig_cnt <= '0; remain <= '0;
    end else begin
      st_v <= accept;
      if (accept) st_d <= trace_data;
      if (st_v) begin
        wp <= wp + PW'(4);
        if (&wp[PW-1:2]) full <= 1'b1;
      end
      if (flush_pend) flush_pend <= 1'b0;
      if (trig_fire) begin
        trig_seen <= 1'b1;
        remain    <= trig_cnt;
      end else if (cap_en && trig_seen && accept) begin
        remain <= remain - CNT_W'(1);
      end
      if ((flush_pend && stop_flush) || trig_stop) cap_en <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            cap_en <= reg_wdata[0];
            if (reg_wdata[0] && !cap_en) trig_seen <= 1'b0;
          end
          A_FLUSH: begin
            stop_flush <= reg_wdata[1];
            if (reg_wdata[0]) flush_pend <= 1'b1;
          end
          A_TRIG: trig_cnt <= reg_wdata[CNT_W-1:0];
          A_RP:   if (ready) rp <= reg_wdata[PW-1:0] & RP_MASK;
          A_WP:   if (ready) begin
                    wp   <= {reg_wdata[PW-1:2], 2'b00};
                    full <= 1'b0;
                  end
          default: ;
        endcase
      end
      if (rd_adv) rp <= rp + PW'(4);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, cap_en};
      A_STAT:  reg_rdata = {29'd0, trig_seen, full, ready};
      A_SIZE:  reg_rdata = 32'(DEPTH);
      A_RP:    reg_rdata = 32'(rp);
      A_WP:    reg_rdata = 32'(wp);
      A_DATA:  reg_rdata = cap_en ? '1 : mem[rp[PW-1:2]];
      A_FLUSH: reg_rdata = {30'd0, stop_flush, flush_pend};
      A_TRIG:  reg_rdata = 32'(trig_cnt);
      A_IDENT: reg_rdata = {21'd0, WCODE, CFG_TYPE, 6'd0};
      default: reg_rdata = '0;
    endcase
  end

  a_r2_wp_step: assert property (@(posedge clk) disable iff (!rst_n)
    st_v |=> wp == $past(wp) + PW'(4));
  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend && !(reg_we && reg_addr == A_FLUSH && reg_wdata[0]) |=> !flush_pend);
  a_r4_stop_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend && stop_flush && !ctrl_wr |=> !cap_en);
  a_r5_trig_stop: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stop && !ctrl_wr |=> !cap_en);
  a_r6_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |=> rp == $past(rp) + PW'(4));
  a_r7_rp_align: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A_RP && ready |=> rp[AL-1:0] == '0);
  a_r8_rp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A_RP && !ready |=> $stable(rp));
endmodule

// File: tb/test_trace_ring_capture.sv
`timescale 1ns/1ps
module test_trace_ring_capture;
  localparam int DEPTH = 16;
  localparam int BYTES = DEPTH * 4;
  localparam int RPM   = BYTES - 16;
  localparam int WPM   = BYTES - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tv = 1'b0, tt = 1'b0, we = 1'b0, rd = 1'b0;
  logic [31:0] td = '0, wd = '0;
  logic [3:0] ra = 4'd1;
  logic [31:0] rdata;
  int checks = 0, errors = 0, ncyc = 0;

  trace_ring_capture #(.DEPTH(DEPTH), .BUS_BITS(128), .CNT_W(8)) i_trace_ring_capture (
    .clk(clk), .rst_n(rst_n), .trace_valid(tv), .trace_data(td), .trace_trig(tt),
    .reg_addr(ra), .reg_we(we), .reg_rd(rd), .reg_wdata(wd), .reg_rdata(rdata));

  always #2.5 clk = ~clk;

  bit m_en, m_stv, m_full, m_fl, m_stop, m_trig, o_ready, acc, nen, old_en;
  int m_wp, m_rp, m_tc, m_rem;
  logic [31:0] m_std;
  logic [31:0] m_mem [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_stv = 0; m_full = 0; m_fl = 0; m_stop = 0; m_trig = 0;
      m_wp = 0; m_rp = 0; m_tc = 0; m_rem = 0; m_std = '0;
    end else begin
      o_ready = !m_en && !m_stv;
      acc = m_en && tv;
      nen = m_en;
      old_en = m_en;
      if (m_stv) begin
        m_mem[m_wp / 4] = m_std;
        if (m_wp == BYTES - 4) m_full = 1;
        m_wp = (m_wp + 4) % BYTES;
      end
      m_stv = acc;
      if (acc) m_std = td;
      if (m_fl) begin m_fl = 0; if (m_stop) nen = 0; end
      if (m_en && tt && !m_trig) begin
        m_trig = 1; m_rem = m_tc;
        if (m_tc == 0) nen = 0;
      end else if (m_en && m_trig && acc) begin
        if (m_rem == 1) nen = 0;
        m_rem = m_rem - 1;
      end
      if (we) begin
        case (ra)
          4'd0: begin nen = wd[0]; if (wd[0] && !old_en) m_trig = 0; end
          4'd6: begin m_stop = wd[1]; if (wd[0]) m_fl = 1; end
          4'd7: m_tc = int'(wd[7:0]);
          4'd3: if (o_ready) m_rp = int'(wd) & RPM;
          4'd4: if (o_ready) begin m_wp = int'(wd) & WPM; m_full = 0; end
          default: ;
        endcase
      end
      if (rd && ra == 4'd5 && !old_en) m_rp = (m_rp + 4) % BYTES;
      m_en = nen;
    end
  end

  function automatic logic [31:0] expect_rd(input logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_en};
      4'd1: return {29'd0, m_trig, m_full, !m_en && !m_stv};
      4'd2: return 32'(DEPTH);
      4'd3: return 32'(m_rp);
      4'd4: return 32'(m_wp);
      4'd5: return m_en ? 32'hFFFF_FFFF : m_mem[m_rp / 4];
      4'd6: return {30'd0, m_stop, m_fl};
      4'd7: return 32'(m_tc);
      4'd8: return 32'h0000_0400;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] a);
    case (a)
      4'd0: return "R1";
      4'd1: return "R3 (status, full R2, trigger R5)";
      4'd2: return "R9";
      4'd3: return "R7 R8";
      4'd4: return "R2 R8";
      4'd5: return "R6";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R10";
      default: return "R10 (unused address)";
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (rdata !== expect_rd(ra)) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", tag(ra), ra, rdata, expect_rd(ra));
      end
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d cycles expected=finish", ncyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit v, input logic [31:0] d, input bit t,
                     input logic [3:0] a, input bit w, input bit r, input logic [31:0] x);
    @(negedge clk);
    tv = v; td = d; tt = t; ra = a; we = w; rd = r; wd = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 4'd1, 0, 0, '0);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] x);
    cyc(0, '0, 0, a, 1, 0, x);
  endtask

  task automatic stream(input int n, input int base, input int trig_at);
    for (int i = 0; i < n; i++) cyc(1, 32'hA000_0000 + 32'(base + i), i == trig_at, 4'd1, 0, 0, '0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 4'd5, 0, 1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state of every register, R9 and R10 included
    for (int a = 0; a < 10; a++) cyc(0, '0, 0, 4'(a), 0, 0, '0);
    // R1 R2: first capture run
    wreg(4'd0, 32'd1);
    stream(10, 0, -1);
    cyc(0, '0, 0, 4'd5, 0, 1, '0);          // R6: all ones while capturing
    wreg(4'd3, 32'h20);                      // R8: ignored during capture
    cyc(0, '0, 0, 4'd3, 0, 0, '0);
    wreg(4'd4, 32'h10);                      // R8
    cyc(0, '0, 0, 4'd4, 0, 0, '0);
    wreg(4'd0, 32'd0);
    idle(2);
    drain(10);                               // R6
    // R2: wrap sets full
    wreg(4'd0, 32'd1);
    stream(20, 100, -1);
    wreg(4'd0, 32'd0);
    cyc(0, '0, 0, 4'd4, 0, 0, '0);
    idle(2);
    wreg(4'd3, 32'h1C);                      // R7: aligned to 0x10
    cyc(0, '0, 0, 4'd3, 0, 0, '0);
    drain(18);                               // R6 wrap of read pointer
    wreg(4'd4, 32'h0B);                      // R2 R8: full clears
    cyc(0, '0, 0, 4'd4, 0, 0, '0);
    idle(1);
    // R4: flush with stop
    wreg(4'd6, 32'd2);
    wreg(4'd0, 32'd1);
    stream(3, 200, -1);
    cyc(1, 32'hB000_0000, 0, 4'd6, 1, 0, 32'd3);
    cyc(1, 32'hB000_0001, 0, 4'd6, 0, 0, '0);
    stream(3, 300, -1);
    cyc(0, '0, 0, 4'd0, 0, 0, '0);
    idle(2);
    // R4: flush without stop keeps capture running
    wreg(4'd6, 32'd0);
    wreg(4'd0, 32'd1);
    cyc(1, 32'hC000_0000, 0, 4'd6, 1, 0, 32'd1);
    cyc(1, 32'hC000_0001, 0, 4'd6, 0, 0, '0);
    stream(3, 400, -1);
    cyc(0, '0, 0, 4'd0, 0, 0, '0);
    wreg(4'd0, 32'd0);
    idle(2);
    // R5: trigger with count 3
    wreg(4'd7, 32'd3);
    cyc(0, '0, 0, 4'd7, 0, 0, '0);
    wreg(4'd0, 32'd1);
    stream(12, 500, 4);
    cyc(0, '0, 0, 4'd0, 0, 0, '0);
    idle(2);
    cyc(0, '0, 0, 4'd4, 0, 0, '0);
    // R5: trigger with count 0, trigger without a word
    wreg(4'd7, 32'd0);
    wreg(4'd0, 32'd1);
    idle(1);
    stream(2, 600, -1);
    cyc(0, '0, 1, 4'd1, 0, 0, '0);
    stream(3, 700, -1);
    cyc(0, '0, 0, 4'd0, 0, 0, '0);
    idle(2);
    wreg(4'd3, 32'h00);
    drain(16);
    for (int a = 0; a < 10; a++) cyc(0, '0, 0, 4'(a), 0, 0, '0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule